// File: doc/BRIEF.md
# Instruction Bundle Dispatch Sequencer

This block takes one 64-bit instruction bundle at a time and turns it into issue requests for two execution units: a memory unit and an integer unit. A bundle holds either one long instruction or two 32-bit short instructions, called the left slot (upper half) and the right slot (lower half). A two-bit format field inside the word selects one of four modes. Both slots can issue together. They can issue one after the other, left first. They can issue one after the other, right first. Or the whole word issues once as a long instruction.

Each slot has its own issue strobe, which is held until the unit answers with a done pulse. With the done pulse the unit also reports a branch-taken flag, a branch target and a kill flag. The sequencer pulses a commit strobe after every issue step. In sequential modes it drops the second slot when the first one branched or killed it. When the bundle ends it pulses `bundle_done` and presents the merged next address. Two branches in the same parallel bundle are reported as a fault, and no address is given.

Bundles arrive on a valid/ready stream. `bnd_ready` is high only while no bundle is in flight. A word offered while ready is low must be held steady by the source and is taken on the first cycle in which valid and ready are both high. The issue handshake works the same way: a strobe stays high, and the instruction halves stay stable, until the unit raises `rsp_done` for that slot. The first strobe appears in the cycle after the bundle is accepted. A commit cycle follows the cycle in which the last done of an issue step arrives.

Top module: `bundle_dispatch`

## Requirements
- R1: `bnd_ready` is 1 after reset and whenever no bundle is in flight, and 0 from the acceptance cycle until `bundle_done` has pulsed. A word held on the input during that time is accepted once the sequencer is idle again.
- R2: The format is {word[63], word[31]}: 0 is parallel, 1 is left then right, 2 is right then left, 3 is long. While a bundle issues, `iss_insn_l` carries word[63:32] and `iss_insn_r` carries word[31:0].
- R3: Parallel mode raises `iss_vld` = 2'b11 together, with `unit_l` = 1 (memory) and `unit_r` = 2 (integer). There is exactly one commit, after both slots are done.
- R4: Left-then-right mode first issues the left slot alone with `unit_l` = 1. It then issues the right slot alone with `unit_r` = 0 (any unit).
- R5: Right-then-left mode first issues the right slot alone with `unit_r` = 2. It then issues the left slot alone with `unit_l` = 0.
- R6: In sequential modes `commit` pulses once after each slot. The second slot is not issued if the first slot reported a branch or a kill.
- R7: Long mode raises `iss_vld` = 2'b10 with `iss_long` = 1 and `unit_l` = 0, followed by a single commit.
- R8: `iss_vld[1]` (left) and `iss_vld[0]` (right) each stay high until that slot's `rsp_done`. A `rsp_done` on a slot whose strobe is low is ignored. A slot whose strobe is low shows unit code 0.
- R9: In sequential and long modes, `nxt_valid` carries the target of the slot that branched and ran. If no slot branched, no address is given.
- R10: In parallel mode, if exactly one slot branches, its target is used. If both branch, `nxt_fault` = 1 and `nxt_valid` = 0.
- R11: `bundle_done` is a one-cycle pulse that coincides with the final commit. `nxt_valid`, `nxt_addr` and `nxt_fault` are nonzero only in that cycle.
- R12: A kill flag has no effect in parallel mode, in long mode, or when it comes from the second slot of a sequential bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_valid | input | 1 | Bundle word offered |
| bnd_ready | output | 1 | Sequencer can take a bundle |
| bnd_word | input | WORD_W | Bundle word |
| iss_vld | output | 2 | Issue strobes, bit 1 left slot, bit 0 right slot |
| iss_long | output | 1 | The left strobe is a long issue of the whole word |
| iss_insn_l | output | WORD_W/2 | Left sub-instruction |
| iss_insn_r | output | WORD_W/2 | Right sub-instruction |
| unit_l | output | 2 | Left slot unit: 0 any, 1 memory, 2 integer |
| unit_r | output | 2 | Right slot unit, same coding |
| rsp_done | input | 2 | Per-slot done response |
| rsp_br | input | 2 | Per-slot branch taken, valid with done |
| rsp_kill | input | 2 | Per-slot kill of the following slot, valid with done |
| rsp_tgt_l | input | ADDR_W | Left slot branch target |
| rsp_tgt_r | input | ADDR_W | Right slot branch target |
| commit | output | 1 | Commit queued writes now |
| bundle_done | output | 1 | Bundle finished |
| nxt_valid | output | 1 | Merged next address is a branch target |
| nxt_addr | output | ADDR_W | Merged next address |
| nxt_fault | output | 1 | Both parallel slots branched |

## Verification
The bench looks for the cases where the two slots can interfere.

- A left slot that completes early in a parallel bundle must drop its strobe while the right one is still waiting. If the strobe stays up, the unit sees a second request.
- Stray done pulses carrying a branch and a kill are driven on idle slots. A design that captured them would suppress slots or invent a target.
- Kills are placed on parallel, long and second-slot positions, where obeying them would cut the commit count.
- Bundles are queued back to back, so a sequencer that dropped or double-took a held word under back-pressure would desynchronise its issue pattern from the expected one.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int SLOT_N = 2;
  localparam int SLOT_L = 1;
  localparam int SLOT_R = 0;

  typedef enum logic [1:0] {
    FMT_PAR  = 2'd0,
    FMT_LR   = 2'd1,
    FMT_RL   = 2'd2,
    FMT_LONG = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    UNIT_ANY = 2'd0,
    UNIT_MEM = 2'd1,
    UNIT_INT = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_COMMIT = 2'd2
  } seq_st_e;

  function automatic fmt_e fmt_of(input logic hi_mark, input logic lo_mark);
    return fmt_e'({hi_mark, lo_mark});
  endfunction

  function automatic logic is_seq(input fmt_e f);
    return (f == FMT_LR) || (f == FMT_RL);
  endfunction

  // Slot index that runs first in a sequential bundle
  function automatic int unsigned lead_slot(input fmt_e f);
    return (f == FMT_RL) ? SLOT_R : SLOT_L;
  endfunction
endpackage

// File: rtl/bd_issue_map.sv
module bd_issue_map
  import bd_pkg::*;
(
  input  fmt_e              fmt,
  input  logic              phase,
  output logic [SLOT_N-1:0] slot_mask,
  output unit_e             unit_l,
  output unit_e             unit_r
);
  always_comb begin
    slot_mask = '0;
    unit_l    = UNIT_ANY;
    unit_r    = UNIT_ANY;
    unique case (fmt)
      FMT_PAR: begin
        slot_mask = 2'b11;
        unit_l    = UNIT_MEM;
        unit_r    = UNIT_INT;
      end
      FMT_LR: begin
        if (!phase) begin
          slot_mask[SLOT_L] = 1'b1;
          unit_l            = UNIT_MEM;
        end else begin
          slot_mask[SLOT_R] = 1'b1;
        end
      end
      FMT_RL: begin
        if (!phase) begin
          slot_mask[SLOT_R] = 1'b1;
          unit_r            = UNIT_INT;
        end else begin
          slot_mask[SLOT_L] = 1'b1;
        end
      end
      default: begin
        slot_mask[SLOT_L] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bd_slot_track.sv
module bd_slot_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              offer,
  input  logic              rsp_done,
  input  logic              rsp_br,
  input  logic              rsp_kill,
  input  logic [ADDR_W-1:0] rsp_tgt,
  output logic              done_q,
  output logic              br_q,
  output logic              kill_q,
  output logic [ADDR_W-1:0] tgt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      br_q   <= 1'b0;
      kill_q <= 1'b0;
      tgt_q  <= '0;
    end else if (clr) begin
      done_q <= 1'b0;
      br_q   <= 1'b0;
      kill_q <= 1'b0;
      tgt_q  <= '0;
    end else if (offer && rsp_done) begin
      done_q <= 1'b1;
      br_q   <= rsp_br;
      kill_q <= rsp_kill;
      tgt_q  <= rsp_tgt;
    end
  end

  // R8: a strobe without its answer persists into the next cycle
  a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (offer && !rsp_done) |=> offer);

  // R8: a finished slot is not re-offered within the same bundle
  a_r8_no_reoffer: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> !offer);
endmodule

// File: rtl/bd_next_merge.sv
module bd_next_merge
  import bd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  fmt_e              fmt,
  input  logic [SLOT_N-1:0] br_vec,
  input  logic [ADDR_W-1:0] tgt_l,
  input  logic [ADDR_W-1:0] tgt_r,
  output logic              tgt_valid,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              dual_fault
);
  logic              lead_is_l;
  logic              lead_br;
  logic              trail_br;
  logic [ADDR_W-1:0] lead_tgt;
  logic [ADDR_W-1:0] trail_tgt;

  assign lead_is_l = (lead_slot(fmt) == SLOT_L);
  assign lead_br   = lead_is_l ? br_vec[SLOT_L] : br_vec[SLOT_R];
  assign trail_br  = lead_is_l ? br_vec[SLOT_R] : br_vec[SLOT_L];
  assign lead_tgt  = lead_is_l ? tgt_l : tgt_r;
  assign trail_tgt = lead_is_l ? tgt_r : tgt_l;

  always_comb begin
    tgt_valid  = 1'b0;
    tgt_addr   = '0;
    dual_fault = 1'b0;
    if (fmt == FMT_PAR) begin
      if (&br_vec) begin
        dual_fault = 1'b1;
      end else if (br_vec[SLOT_L]) begin
        tgt_valid = 1'b1;
        tgt_addr  = tgt_l;
      end else if (br_vec[SLOT_R]) begin
        tgt_valid = 1'b1;
        tgt_addr  = tgt_r;
      end
    end else if (lead_br) begin
      tgt_valid = 1'b1;
      tgt_addr  = lead_tgt;
    end else if (trail_br) begin
      tgt_valid = 1'b1;
      tgt_addr  = trail_tgt;
    end
  end
endmodule

// File: rtl/bd_seq_ctrl.sv
module bd_seq_ctrl
  import bd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  fmt_e              fmt_in,
  input  logic [SLOT_N-1:0] slot_mask,
  input  logic [SLOT_N-1:0] done_vec,
  input  logic [SLOT_N-1:0] rsp_done,
  input  logic [SLOT_N-1:0] br_vec,
  input  logic [SLOT_N-1:0] kill_vec,
  output logic              in_ready,
  output logic              accept,
  output fmt_e              fmt_q,
  output logic              phase_q,
  output logic [SLOT_N-1:0] offer,
  output logic              commit,
  output logic              finish,
  output logic              clr
);
  seq_st_e           st_q;
  logic              step_done;
  logic              last_step;
  logic [SLOT_N-1:0] remaining;

  assign in_ready  = (st_q == ST_IDLE);
  assign accept    = in_ready && in_valid;
  assign offer     = (st_q == ST_ISSUE) ? (slot_mask & ~done_vec) : '0;
  assign remaining = offer & ~rsp_done;
  assign step_done = (st_q == ST_ISSUE) && (remaining == '0);

  // The bundle ends after this commit unless a sequential second slot is still due
  assign last_step = !is_seq(fmt_q) || phase_q ||
                     br_vec[lead_slot(fmt_q)] || kill_vec[lead_slot(fmt_q)];

  assign commit = (st_q == ST_COMMIT);
  assign finish = commit && last_step;
  assign clr    = accept || finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fmt_q   <= FMT_PAR;
      phase_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            st_q    <= ST_ISSUE;
            fmt_q   <= fmt_in;
            phase_q <= 1'b0;
          end
        end
        ST_ISSUE: begin
          if (step_done) st_q <= ST_COMMIT;
        end
        ST_COMMIT: begin
          if (last_step) begin
            st_q <= ST_IDLE;
          end else begin
            st_q    <= ST_ISSUE;
            phase_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4: sequential modes never offer both slots at once
  a_r4_seq_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (is_seq(fmt_q) && (st_q == ST_ISSUE)) |-> ($countones(offer) <= 1));

  // R6: each commit is a single-cycle pulse
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R3: a parallel bundle commits only once, so its commit is always final
  a_r3_par_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (fmt_q == FMT_PAR)) |-> finish);
endmodule

// File: rtl/bundle_dispatch.sv
module bundle_dispatch
  import bd_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bnd_valid,
  output logic                  bnd_ready,
  input  logic [WORD_W-1:0]     bnd_word,
  output logic [SLOT_N-1:0]     iss_vld,
  output logic                  iss_long,
  output logic [WORD_W/2-1:0]   iss_insn_l,
  output logic [WORD_W/2-1:0]   iss_insn_r,
  output logic [1:0]            unit_l,
  output logic [1:0]            unit_r,
  input  logic [SLOT_N-1:0]     rsp_done,
  input  logic [SLOT_N-1:0]     rsp_br,
  input  logic [SLOT_N-1:0]     rsp_kill,
  input  logic [ADDR_W-1:0]     rsp_tgt_l,
  input  logic [ADDR_W-1:0]     rsp_tgt_r,
  output logic                  commit,
  output logic                  bundle_done,
  output logic                  nxt_valid,
  output logic [ADDR_W-1:0]     nxt_addr,
  output logic                  nxt_fault
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] word_q;
  logic              accept;
  logic              clr;
  logic              phase_q;
  fmt_e              fmt_q;
  fmt_e              fmt_in;
  logic [SLOT_N-1:0] slot_mask;
  logic [SLOT_N-1:0] offer;
  logic [SLOT_N-1:0] done_vec;
  logic [SLOT_N-1:0] br_vec;
  logic [SLOT_N-1:0] kill_vec;
  logic [ADDR_W-1:0] tgt_in [SLOT_N];
  logic [ADDR_W-1:0] tgt_q  [SLOT_N];
  unit_e             map_ul;
  unit_e             map_ur;
  logic              m_valid;
  logic              m_fault;
  logic [ADDR_W-1:0] m_addr;

  assign fmt_in = fmt_of(bnd_word[WORD_W-1], bnd_word[HALF_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (accept) word_q <= bnd_word;
  end

  bd_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (bnd_valid),
    .fmt_in    (fmt_in),
    .slot_mask (slot_mask),
    .done_vec  (done_vec),
    .rsp_done  (rsp_done),
    .br_vec    (br_vec),
    .kill_vec  (kill_vec),
    .in_ready  (bnd_ready),
    .accept    (accept),
    .fmt_q     (fmt_q),
    .phase_q   (phase_q),
    .offer     (offer),
    .commit    (commit),
    .finish    (bundle_done),
    .clr       (clr)
  );

  bd_issue_map u_map (
    .fmt       (fmt_q),
    .phase     (phase_q),
    .slot_mask (slot_mask),
    .unit_l    (map_ul),
    .unit_r    (map_ur)
  );

  assign tgt_in[SLOT_L] = rsp_tgt_l;
  assign tgt_in[SLOT_R] = rsp_tgt_r;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    bd_slot_track #(.ADDR_W(ADDR_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .offer    (offer[s]),
      .rsp_done (rsp_done[s]),
      .rsp_br   (rsp_br[s]),
      .rsp_kill (rsp_kill[s]),
      .rsp_tgt  (tgt_in[s]),
      .done_q   (done_vec[s]),
      .br_q     (br_vec[s]),
      .kill_q   (kill_vec[s]),
      .tgt_q    (tgt_q[s])
    );
  end

  bd_next_merge #(.ADDR_W(ADDR_W)) u_merge (
    .fmt        (fmt_q),
    .br_vec     (br_vec),
    .tgt_l      (tgt_q[SLOT_L]),
    .tgt_r      (tgt_q[SLOT_R]),
    .tgt_valid  (m_valid),
    .tgt_addr   (m_addr),
    .dual_fault (m_fault)
  );

  assign iss_vld    = offer;
  assign iss_long   = offer[SLOT_L] && (fmt_q == FMT_LONG);
  assign iss_insn_l = word_q[WORD_W-1:HALF_W];
  assign iss_insn_r = word_q[HALF_W-1:0];
  assign unit_l     = offer[SLOT_L] ? map_ul : UNIT_ANY;
  assign unit_r     = offer[SLOT_R] ? map_ur : UNIT_ANY;
  assign nxt_valid  = bundle_done && m_valid;
  assign nxt_fault  = bundle_done && m_fault;
  assign nxt_addr   = nxt_valid ? m_addr : '0;

  // R1: an accepted bundle closes the input until it completes
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_valid && bnd_ready) |=> !bnd_ready);

  // R1: the input reopens right after completion
  a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    bundle_done |=> bnd_ready);

  // R11: completion coincides with a commit
  a_r11_done_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    bundle_done |-> commit);

  // R11: next-address outputs only appear at completion
  a_r11_nxt_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_valid || nxt_fault) |-> bundle_done);

  // R10: a fault never comes with an address
  a_r10_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !(nxt_valid && nxt_fault));

  // R7: a long issue never strobes the right slot
  a_r7_long_left_only: assert property (@(posedge clk) disable iff (!rst_n)
    iss_long |-> (iss_vld == 2'b10));

  // R1: no issue while the input is open
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_ready |-> ((iss_vld == '0) && !commit));
endmodule

// File: tb/bundle_dispatch_bench.sv
module bundle_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd_valid = 1'b0;
  logic        bnd_ready;
  logic [63:0] bnd_word = '0;
  logic [1:0]  iss_vld;
  logic        iss_long;
  logic [31:0] iss_insn_l, iss_insn_r;
  logic [1:0]  unit_l, unit_r;
  logic [1:0]  rsp_done = '0, rsp_br = '0, rsp_kill = '0;
  logic [31:0] rsp_tgt_l = '0, rsp_tgt_r = '0;
  logic        commit, bundle_done, nxt_valid, nxt_fault;
  logic [31:0] nxt_addr;

  always #10 clk = ~clk;

  bundle_dispatch u_bundle_dispatch (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
    .bnd_word(bnd_word), .iss_vld(iss_vld), .iss_long(iss_long),
    .iss_insn_l(iss_insn_l), .iss_insn_r(iss_insn_r), .unit_l(unit_l),
    .unit_r(unit_r), .rsp_done(rsp_done), .rsp_br(rsp_br), .rsp_kill(rsp_kill),
    .rsp_tgt_l(rsp_tgt_l), .rsp_tgt_r(rsp_tgt_r), .commit(commit),
    .bundle_done(bundle_done), .nxt_valid(nxt_valid), .nxt_addr(nxt_addr),
    .nxt_fault(nxt_fault)
  );

  typedef struct packed {
    logic [63:0] word;
    logic        brl, brr, kl, kr;
    logic [31:0] tl, tr;
    logic [3:0]  dl, dr;
    logic        stray;
  } case_t;

  case_t       pend[$];
  case_t       cur;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic        run = 1'b0;
  int          m_st = 0, m_step = 0, m_fmt = 0, obs = 0;
  logic [1:0]  m_dn = '0, m_br = '0, m_kill = '0, prev_vld = '0;
  logic [31:0] m_tgt [2];
  int          cnt [2];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_word(input logic [1:0] f, input logic [31:0] a,
                                          input logic [31:0] b);
    return {f[1], a[30:0], f[0], b[30:0]};
  endfunction

  function automatic logic [1:0] step_mask(input int f, input int st);
    if (f == 0) return 2'b11;
    if (f == 3) return 2'b10;
    if (f == 1) return (st == 0) ? 2'b10 : 2'b01;
    return (st == 0) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] unit_for(input int f, input int st, input int s);
    if (f == 0) return (s == 1) ? 2'd1 : 2'd2;
    if (f == 1 && st == 0) return 2'd1;
    if (f == 2 && st == 0) return 2'd2;
    return 2'd0;
  endfunction

  function automatic string mode_tag(input int f);
    case (f)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic add(input logic [1:0] f, input logic brl, input logic brr,
                     input logic kl, input logic kr, input int dl, input int dr,
                     input logic stray);
    case_t c;
    c.word  = mk_word(f, 32'h1234_5600 + pend.size(), 32'h0BCD_0000 + pend.size());
    c.brl   = brl; c.brr = brr; c.kl = kl; c.kr = kr;
    c.tl    = 32'h0000_1000 + 32'(pend.size() * 16);
    c.tr    = 32'h0000_2000 + 32'(pend.size() * 16);
    c.dl    = 4'(dl); c.dr = 4'(dr); c.stray = stray;
    pend.push_back(c);
  endtask

  always @(negedge clk) begin
    if (run) begin
      logic [1:0]  ev, evu_l, evu_r;
      logic        last, ev_val, ev_flt;
      logic [31:0] ev_addr;
      int          f, o, exp_n;
      cyc++;
      f = (m_fmt == 2) ? 0 : 1;
      o = 1 - f;
      ev    = (m_st == 1) ? (step_mask(m_fmt, m_step) & ~m_dn) : 2'b00;
      evu_l = ev[1] ? unit_for(m_fmt, m_step, 1) : 2'd0;
      evu_r = ev[0] ? unit_for(m_fmt, m_step, 0) : 2'd0;
      last  = (m_st == 2) && ((m_fmt == 0) || (m_fmt == 3) || (m_step == 1) ||
                              m_br[f] || m_kill[f]);
      ev_val = 1'b0; ev_flt = 1'b0; ev_addr = '0;
      if (last) begin
        if (m_fmt == 0) begin
          if (m_br == 2'b11) ev_flt = 1'b1;
          else if (m_br[1]) begin ev_val = 1'b1; ev_addr = m_tgt[1]; end
          else if (m_br[0]) begin ev_val = 1'b1; ev_addr = m_tgt[0]; end
        end else if (m_br[f]) begin ev_val = 1'b1; ev_addr = m_tgt[f]; end
        else if (m_br[o]) begin ev_val = 1'b1; ev_addr = m_tgt[o]; end
      end

      chk("R1 ready", 64'(bnd_ready), 64'(m_st == 0));
      chk((ev != 0 && ev == prev_vld) ? "R8 strobe held" : {mode_tag(m_fmt), " strobes"},
          64'(iss_vld), 64'(ev));
      chk({mode_tag(m_fmt), " long flag"}, 64'(iss_long), 64'(ev[1] && m_fmt == 3));
      chk({mode_tag(m_fmt), " unit_l R8"}, 64'(unit_l), 64'(evu_l));
      chk({mode_tag(m_fmt), " unit_r R8"}, 64'(unit_r), 64'(evu_r));
      if (m_st == 1) chk("R2 halves", {iss_insn_l, iss_insn_r}, cur.word);
      chk("R6 commit", 64'(commit), 64'(m_st == 2));
      chk("R11 bundle_done", 64'(bundle_done), 64'(last));
      chk((m_fmt == 0) ? "R10 nxt_valid" : "R9 nxt_valid", 64'(nxt_valid), 64'(ev_val));
      chk((m_fmt == 0) ? "R10 nxt_addr" : "R9 nxt_addr", 64'(nxt_addr), 64'(ev_addr));
      chk("R10 nxt_fault", 64'(nxt_fault), 64'(ev_flt));
      prev_vld = ev;

      // drive bundle stream
      bnd_valid = (pend.size() != 0);
      bnd_word  = bnd_valid ? pend[0].word : 64'h0;

      // responder acting as both units
      rsp_done = '0; rsp_br = '0; rsp_kill = '0; rsp_tgt_l = '0; rsp_tgt_r = '0;
      for (int s = 0; s < 2; s++) begin
        if (ev[s]) begin
          if (cnt[s] == int'((s == 1) ? cur.dl : cur.dr)) begin
            rsp_done[s] = 1'b1;
            rsp_br[s]   = (s == 1) ? cur.brl : cur.brr;
            rsp_kill[s] = (s == 1) ? cur.kl : cur.kr;
            if (s == 1) rsp_tgt_l = cur.tl; else rsp_tgt_r = cur.tr;
          end
          cnt[s]++;
        end else begin
          cnt[s] = 0;
          if (cur.stray && m_st == 1) begin
            rsp_done[s] = 1'b1;
            rsp_br[s]   = 1'b1;
            rsp_kill[s] = 1'b1;
            if (s == 1) rsp_tgt_l = 32'hBAD0_0001; else rsp_tgt_r = 32'hBAD0_0000;
          end
        end
      end

      // reference model advance
      case (m_st)
        0: if (bnd_valid) begin
          cur = pend.pop_front();
          m_fmt = int'({cur.word[63], cur.word[31]});
          m_st = 1; m_step = 0; m_dn = '0; m_br = '0; m_kill = '0; obs = 0;
        end
        1: begin
          for (int s = 0; s < 2; s++) begin
            if (ev[s] && rsp_done[s]) begin
              m_dn[s] = 1'b1; m_br[s] = rsp_br[s]; m_kill[s] = rsp_kill[s];
              m_tgt[s] = (s == 1) ? rsp_tgt_l : rsp_tgt_r;
              obs++;
            end
          end
          if ((step_mask(m_fmt, m_step) & ~m_dn) == 2'b00) m_st = 2;
        end
        default: begin
          if (last) begin
            if (m_fmt == 0) exp_n = 2;
            else if (m_fmt == 3) exp_n = 1;
            else if (m_fmt == 1) exp_n = (cur.brl || cur.kl) ? 1 : 2;
            else exp_n = (cur.brr || cur.kr) ? 1 : 2;
            if ((m_fmt == 0 || m_fmt == 3) && (cur.kl || cur.kr))
              chk("R12 slots run", 64'(obs), 64'(exp_n));
            else
              chk("R6 slots run", 64'(obs), 64'(exp_n));
            m_st = 0;
          end else begin
            m_step = 1; m_st = 1;
          end
        end
      endcase
    end
  end

  initial begin
    m_tgt[0] = '0; m_tgt[1] = '0; cnt[0] = 0; cnt[1] = 0;
    cur = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset ready", 64'(bnd_ready), 64'd1);
    chk("R8 reset strobes", 64'(iss_vld), 64'd0);
    chk("R11 reset done", 64'(bundle_done), 64'd0);
    //  fmt  brl  brr  kl   kr   dl dr stray
    add(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2, 1'b0); // R3 parallel, skewed done
    add(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1, 0, 1'b0); // R10 left branch only
    add(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 3, 1'b1); // R10 right branch, R8 strays
    add(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2, 1, 1'b0); // R10 dual branch fault
    add(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, 1'b0); // R12 parallel kill ignored
    add(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1, 1, 1'b0); // R4 both run, R9 right target
    add(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 1'b1); // R6 left branch suppresses right
    add(2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2, 0, 1'b0); // R6 left kill suppresses right
    add(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0); // R12 kill from second slot
    add(2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 0, 2, 1'b0); // R5 right branch suppresses left
    add(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1, 0, 1'b1); // R5 left second, R9 left target
    add(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1, 1'b0); // R6 right kill
    add(2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0); // R7 long branch, R12 kill ignored
    add(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3, 0, 1'b1); // R7 long, slow, strays
    run = 1'b1;
    while ((pend.size() != 0 || m_st != 0) && cyc < 5000) @(negedge clk);
    if (cyc >= 5000) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer than 5000", cyc);
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule